// File: doc/BRIEF.md
# Programmable Address Window Decoder

This block is a bank of programmable address windows. It steers a 44-bit physical address to a 4-bit target ID. Software sets up each window through a plain 32-bit register port. A window has a control word that holds its enable bit and its target, plus two address words that give its first and last 64 MB granule.

For each request the block compares the address granule, which is bits [43:26], against every enabled window. One clock cycle later it returns a registered response that carries a hit flag, the target and a miss flag. A single global register holds a bypass bit. When that bit is set, an address that matches no window does not raise the miss flag.

Top module: `addr_window_decoder`

## Requirements
- R1: After reset every window is disabled, the bypass bit is 0, `rsp_valid` is 0 and every register reads back as 0.
- R2: Window n owns three registers at byte offsets n*0x10 + {0x0, 0x8, 0xC}. The control word at +0x0 has the enable in bit 0 and the target in bits [11:8]. The start word at +0x8 and the end word at +0xC each hold an 18-bit granule number in bits [27:10]. A read returns the written value in these bits and 0 in every other bit.
- R3: The global register sits at offset NUM_WIN*0x10, which is 0x100 by default. It holds the miss-bypass bit in bit 1, and every other bit reads as 0.
- R4: A write to an offset that is not listed in R2 or R3 has no effect. This covers +0x4 inside a window slot and any other offset in the global slot. A read of such an offset returns 0.
- R5: A request hits window n when the window is enabled and start <= addr[43:26] <= end. Both bounds are inclusive, and addr[25:0] plays no part in the match.
- R6: When several enabled windows match, the window with the lowest number supplies the target.
- R7: The response appears one cycle after the request. `rsp_valid` is high exactly in the cycle that follows a cycle with `req_valid` high, and back-to-back requests give back-to-back responses. `rsp_hit` and `rsp_miss` are 0 whenever `rsp_valid` is 0.
- R8: When a valid request matches no window, `rsp_hit` is 0 and `rsp_target` is 0. `rsp_miss` is then 1 if the bypass bit is 0 and 0 if it is 1. `rsp_hit` and `rsp_miss` are never both 1.
- R9: Clearing a window's enable bit removes the window from decoding. Its target, start and end fields keep their values and can still be read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| req_valid | input | 1 | Decode request strobe |
| req_addr | input | 44 | Physical address to decode |
| rsp_valid | output | 1 | Response strobe, one cycle after the request |
| rsp_hit | output | 1 | Address matched an enabled window |
| rsp_target | output | 4 | Target ID of the winning window, 0 on no hit |
| rsp_miss | output | 1 | No window matched and bypass is off |

## Verification
The hardest case to reach is the overlap case. Two enabled windows must both claim the same granule, and the request must land exactly on a shared bound, because that is where a priority error and an off-by-one compare error both show up. The bench programs overlapping windows, a one-granule window and a window at the top granule. It then walks addresses that sit on each inclusive edge, with the low 26 bits both all-zero and all-one. After that it disables a window that still has its fields programmed and repeats the overlap address, to show that the next window takes over.

// File: rtl/addr_window_decoder.sv
module addr_window_decoder #(
  parameter int NUM_WIN = 16,
  parameter int AW      = 44,
  parameter int GRAN    = 26,
  parameter int TW      = 4,
  parameter int RAW     = 12
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           reg_we,
  input  logic [RAW-1:0] reg_addr,
  input  logic [31:0]    reg_wdata,
  output logic [31:0]    reg_rdata,
  input  logic           req_valid,
  input  logic [AW-1:0]  req_addr,
  output logic           rsp_valid,
  output logic           rsp_hit,
  output logic [TW-1:0]  rsp_target,
  output logic           rsp_miss
);
  localparam int FW   = AW - GRAN;
  localparam int FLSB = 10;
  localparam int IDXW = RAW - 4;
  localparam int IW   = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1;
  localparam logic [IDXW-1:0] GIDX = IDXW'(NUM_WIN);

  logic [NUM_WIN-1:0] en;
  logic [TW-1:0]      tgt [NUM_WIN];
  logic [FW-1:0]      lo  [NUM_WIN];
  logic [FW-1:0]      hi  [NUM_WIN];
  logic               bypass;

  wire [IDXW-1:0] idx    = reg_addr[RAW-1:4];
  wire [3:0]      off    = reg_addr[3:0];
  wire [IW-1:0]   wi     = idx[IW-1:0];
  wire            in_win = idx < GIDX;
  wire            in_glb = (idx == GIDX) && (off == 4'h0);
  wire [FW-1:0]   fld    = req_addr[AW-1:GRAN];
  wire            unused_bits = ^{reg_wdata[31:FLSB+FW], req_addr[GRAN-1:0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en     <= '0;
      bypass <= 1'b0;
      for (int i = 0; i < NUM_WIN; i++) begin
        tgt[i] <= '0;
        lo[i]  <= '0;
        hi[i]  <= '0;
      end
    end else if (reg_we) begin
      if (in_win) begin
        case (off)
          4'h0: begin
            en[wi]  <= reg_wdata[0];
            tgt[wi] <= reg_wdata[8 +: TW];
          end
          4'h8: lo[wi] <= reg_wdata[FLSB +: FW];
          4'hC: hi[wi] <= reg_wdata[FLSB +: FW];
          default: ;
        endcase
      end else if (in_glb) begin
        bypass <= reg_wdata[1];
      end
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (in_win) begin
      case (off)
        4'h0: begin
          reg_rdata[0]       = en[wi];
          reg_rdata[8 +: TW] = tgt[wi];
        end
        4'h8: reg_rdata[FLSB +: FW] = lo[wi];
        4'hC: reg_rdata[FLSB +: FW] = hi[wi];
        default: ;
      endcase
    end else if (in_glb) begin
      reg_rdata[1] = bypass;
    end
  end

  logic [NUM_WIN-1:0] match;
  for (genvar g = 0; g < NUM_WIN; g++) begin : g_cmp
    assign match[g] = en[g] && (fld >= lo[g]) && (fld <= hi[g]);
  end

  logic          pick_hit;
  logic [TW-1:0] pick_tgt;
  always_comb begin
    pick_hit = 1'b0;
    pick_tgt = '0;
    for (int i = NUM_WIN - 1; i >= 0; i--) begin
      if (match[i]) begin
        pick_hit = 1'b1;
        pick_tgt = tgt[i];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid  <= 1'b0;
      rsp_hit    <= 1'b0;
      rsp_target <= '0;
      rsp_miss   <= 1'b0;
    end else begin
      rsp_valid  <= req_valid;
      rsp_hit    <= req_valid && pick_hit;
      rsp_target <= req_valid ? pick_tgt : '0;
      rsp_miss   <= req_valid && !pick_hit && !bypass;
    end
  end

  AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n) req_valid |=> rsp_valid); // R7
  AST_NO_RSP_WITHOUT_REQ: assert property (@(posedge clk) disable iff (!rst_n) !req_valid |=> !rsp_valid); // R7
  AST_FLAGS_NEED_VALID: assert property (@(posedge clk) disable iff (!rst_n) (rsp_hit || rsp_miss) |-> rsp_valid); // R7
  AST_HIT_MISS_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(rsp_hit && rsp_miss)); // R8
  AST_MISS_NO_BYPASS: assert property (@(posedge clk) disable iff (!rst_n) rsp_miss |-> !$past(bypass)); // R8
  AST_NOHIT_ZERO_TGT: assert property (@(posedge clk) disable iff (!rst_n) !rsp_hit |-> (rsp_target == '0)); // R8
endmodule

// File: tb/tb_addr_window_decoder.sv
`timescale 1ns/1ps
module tb_addr_window_decoder;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [11:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        req_valid = 1'b0;
  logic [43:0] req_addr = '0;
  logic        rsp_valid, rsp_hit, rsp_miss;
  logic [3:0]  rsp_target;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  addr_window_decoder dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .req_valid(req_valid),
    .req_addr(req_addr), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
    .rsp_target(rsp_target), .rsp_miss(rsp_miss)
  );

  // entry: {granule[17:0], low[25:0], hit, target[3:0], miss}
  localparam int NV = 11;
  localparam logic [49:0] VEC [NV] = '{
    {18'h00010, 26'h0000000, 1'b1, 4'h3, 1'b0},  // R5 start bound
    {18'h0001F, 26'h3FFFFFF, 1'b1, 4'h3, 1'b0},  // R5 end bound inclusive
    {18'h00018, 26'h0000000, 1'b1, 4'h3, 1'b0},  // R6 overlap
    {18'h0001F, 26'h0000000, 1'b1, 4'h3, 1'b0},  // R6 overlap edge
    {18'h00020, 26'h0000001, 1'b1, 4'h5, 1'b0},  // R5
    {18'h00040, 26'h0000123, 1'b1, 4'h5, 1'b0},  // R5 end bound
    {18'h00041, 26'h0000000, 1'b0, 4'h0, 1'b1},  // R8 past end
    {18'h0000F, 26'h3FFFFFF, 1'b0, 4'h0, 1'b1},  // R8 below start
    {18'h00100, 26'h2AAAAAA, 1'b1, 4'hA, 1'b0},  // R5 single granule
    {18'h00250, 26'h0000000, 1'b0, 4'h0, 1'b1},  // R9 disabled window
    {18'h3FFFF, 26'h3FFFFFF, 1'b1, 4'hF, 1'b0}   // R5 top granule
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic win(input int n, input logic [3:0] t, input logic e,
                     input logic [17:0] s, input logic [17:0] f);
    wr(12'(n * 16 + 8),  {4'h0, s, 10'h0});
    wr(12'(n * 16 + 12), {4'h0, f, 10'h0});
    wr(12'(n * 16),      {20'h0, t, 7'h0, e});
  endtask

  task automatic req(input string r, input logic [17:0] g, input logic [25:0] lowb,
                     input logic eh, input logic [3:0] et, input logic em);
    @(negedge clk);
    req_valid = 1'b1; req_addr = {g, lowb};
    @(negedge clk);
    req_valid = 1'b0;
    chk({r, " valid"}, 64'(rsp_valid), 64'(1'b1));
    chk({r, " hit"}, 64'(rsp_hit), 64'(eh));
    chk({r, " target"}, 64'(rsp_target), 64'(et));
    chk({r, " miss"}, 64'(rsp_miss), 64'(em));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chk("R1 rsp_valid", 64'(rsp_valid), 64'(0));
    rd(12'h000, d); chk("R1 ctrl0", 64'(d), 64'(0));
    rd(12'h0F8, d); chk("R1 start15", 64'(d), 64'(0));
    rd(12'h100, d); chk("R1 global", 64'(d), 64'(0));
    req("R1 no windows miss", 18'h00010, 26'h0, 1'b0, 4'h0, 1'b1);

    win(0, 4'h3, 1'b1, 18'h00010, 18'h0001F);
    win(1, 4'h5, 1'b1, 18'h00018, 18'h00040);
    win(2, 4'hA, 1'b1, 18'h00100, 18'h00100);
    win(3, 4'h7, 1'b0, 18'h00200, 18'h002FF);
    win(15, 4'hF, 1'b1, 18'h3FFFF, 18'h3FFFF);

    for (int i = 0; i < NV; i++) begin
      req($sformatf("R5 vec%0d", i), VEC[i][49:32], VEC[i][31:6],
          VEC[i][5], VEC[i][4:1], VEC[i][0]);
    end

    // R2 readback masks
    wr(12'h040, 32'hFFFF_FFFF);
    rd(12'h040, d); chk("R2 ctrl mask", 64'(d), 64'h0000_0F01);
    wr(12'h048, 32'hFFFF_FFFF);
    rd(12'h048, d); chk("R2 start mask", 64'(d), 64'h0FFF_FC00);
    wr(12'h04C, 32'h0000_0000);
    rd(12'h04C, d); chk("R2 end", 64'(d), 64'h0);
    rd(12'h038, d); chk("R2 win3 start", 64'(d), 64'h0008_0000);

    // R4 undecoded writes ignored
    wr(12'h044, 32'hFFFF_FFFF);
    rd(12'h044, d); chk("R4 hole reads 0", 64'(d), 64'h0);
    rd(12'h040, d); chk("R4 ctrl unchanged", 64'(d), 64'h0000_0F01);
    rd(12'h048, d); chk("R4 start unchanged", 64'(d), 64'h0FFF_FC00);
    wr(12'h108, 32'hFFFF_FFFF);
    rd(12'h100, d); chk("R4 global unchanged", 64'(d), 64'h0);
    rd(12'h108, d); chk("R4 global hole", 64'(d), 64'h0);

    // R3 / R8 bypass
    wr(12'h100, 32'hFFFF_FFFF);
    rd(12'h100, d); chk("R3 global mask", 64'(d), 64'h2);
    req("R8 bypass no miss", 18'h00041, 26'h0, 1'b0, 4'h0, 1'b0);
    wr(12'h100, 32'h0);
    req("R8 bypass off miss", 18'h00041, 26'h0, 1'b0, 4'h0, 1'b1);
    wr(12'h100, 32'h2);

    // R9 disable keeps fields
    wr(12'h000, 32'h0000_0300);
    rd(12'h000, d); chk("R9 ctrl", 64'(d), 64'h300);
    rd(12'h008, d); chk("R9 start kept", 64'(d), 64'h0000_4000);
    rd(12'h00C, d); chk("R9 end kept", 64'(d), 64'h0000_7C00);
    req("R9 disabled no hit", 18'h00010, 26'h0, 1'b0, 4'h0, 1'b0);
    req("R9 next window wins", 18'h00018, 26'h0, 1'b1, 4'h5, 1'b0);

    // R7 back-to-back
    @(negedge clk);
    req_valid = 1'b1; req_addr = {18'h00100, 26'h0};
    @(negedge clk);
    req_addr = {18'h00020, 26'h0};
    chk("R7 first valid", 64'(rsp_valid), 64'(1));
    chk("R7 first target", 64'(rsp_target), 64'hA);
    @(negedge clk);
    req_valid = 1'b0;
    chk("R7 second valid", 64'(rsp_valid), 64'(1));
    chk("R7 second target", 64'(rsp_target), 64'h5);
    @(negedge clk);
    chk("R7 idle valid", 64'(rsp_valid), 64'(0));
    chk("R7 idle hit", 64'(rsp_hit), 64'(0));

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule